// File: doc/BRIEF.md
# Serial Register Access Master

This block lets on-chip logic read and write single 8-bit registers in an external peripheral over a four-wire serial link. The peripheral is addressed by a chip-address byte whose least significant bit selects the direction (0 = write, 1 = read). A caller presents one request with a direction flag, the chip address, the register address and, for writes, a data byte. The block then runs the whole serial exchange on its own. When it finishes, it pulses `done`, and for a read it presents the returned byte on `rdata` at the same time.

A write uses one chip-select window that carries three bytes: the chip address with its low bit cleared, the register address, and the data. A read uses two windows. The first window carries the chip address with its low bit cleared and the register address, which points the peripheral at the register. Chip select is then released. The second window carries the chip address with its low bit set, followed by eight clocks during which the peripheral returns the register contents. A parameter sets the length of each serial clock half-phase in system clocks, so the peripheral's minimum phase time can be met at any system clock rate.

Top module: `spi_reg_master`

## Requirements
- R1: While reset is held and after it, the outputs are idle: `cs_n`=1, `sclk`=1, `mosi`=0, `busy`=0, `done`=0.
- R2: A write request (`rw`=0) produces one window with `cs_n` low for 24 serial bits, MSB first. The bits are the chip address with bit 0 forced to 0, then the register address, then the data byte.
- R3: Each serial bit has a low half of `sclk` lasting HALF_CYC system clocks, followed by a high half lasting HALF_CYC system clocks. `mosi` changes only at the start of the low half and is held through the rising edge and the high half.
- R4: A read request (`rw`=1) produces a first window of 16 bits: the chip address with bit 0 = 0, then the register address. A gap follows. A second window then sends the chip address with bit 0 = 1, and then runs 8 more bits with `mosi`=0. During those 8 bits, `miso` is sampled at the end of each low half, MSB first, and the result appears on `rdata`.
- R5: After every window, `cs_n` stays high with `sclk` high for HALF_CYC system clocks before the next window starts or the transaction ends.
- R6: `busy` rises in the cycle after a request is accepted and stays high until the final gap has elapsed. `done` is a single-cycle pulse in the first cycle with `busy` low. For a read, `rdata` holds the received byte at that cycle.
- R7: A request raised while `busy` is high is ignored. The serial stream in progress continues unchanged and no new transaction starts.
- R8: Bit 0 of the `chip_addr` input has no effect on the serial stream. It is replaced by the direction bit of each window.
- R9: While `cs_n` is high, `sclk` is high and `mosi` is 0. A request is accepted in any cycle with `busy` low, including the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Start a transaction (taken when not busy) |
| rw | input | 1 | 1 = read, 0 = write |
| chip_addr | input | 8 | Peripheral chip address (bit 0 is replaced) |
| reg_addr | input | 8 | Register address within the peripheral |
| wdata | input | 8 | Byte to write |
| rdata | output | 8 | Byte returned by the last read |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| sclk | output | 1 | Serial clock, idles high |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to the peripheral |
| miso | input | 1 | Serial data from the peripheral |

## Verification
The bench builds the full expected waveform of every transaction and compares it on every clock. This catches a design that shortens a half-phase, changes `mosi` on the rising edge, or drops the chip-select gap between the two read windows. During the read-back clocks, `miso` carries the response bit only in the low halves and toggles junk in the high halves, so a design that samples after the rising edge returns a corrupted byte. Requests with chip address bit 0 already set, and stray requests injected mid-transaction, expose a design that passes the raw chip address through or restarts while busy. Back-to-back requests issued in the `done` cycle catch a design that refuses work one cycle too long.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2,
    PH_GAP  = 2'd3
  } phase_e;

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int unsigned HALF_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam int unsigned CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == CNT_LAST);

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: a half-phase never runs past HALF_CYC cycles
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST);

endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned FRAME_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_val,
  input  logic               shift_en,
  input  logic               sample_en,
  input  logic               miso,
  output logic               tx_bit,
  output logic [BYTE_W-1:0]  rx_byte
);

  logic [FRAME_W-1:0] tx_q, tx_d;
  logic [BYTE_W-1:0]  rx_q, rx_d;

  always_comb begin
    tx_d = tx_q;
    if (load)          tx_d = load_val;
    else if (shift_en) tx_d = {tx_q[FRAME_W-2:0], 1'b0};
  end

  always_comb begin
    rx_d = rx_q;
    if (sample_en) rx_d = {rx_q[BYTE_W-2:0], miso};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (load || shift_en) tx_q <= tx_d;
      if (sample_en)        rx_q <= rx_d;
    end
  end

  assign tx_bit  = tx_q[FRAME_W-1];
  assign rx_byte = rx_q;

  // R4: the sequencer never loads a frame and samples in the same cycle
  p_no_load_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && sample_en));

endmodule

// File: rtl/spi_txn_seq.sv
module spi_txn_seq
  import spi_reg_pkg::*;
#(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned FRAME_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic               rw,
  input  logic [BYTE_W-1:0]  chip_addr,
  input  logic [BYTE_W-1:0]  reg_addr,
  input  logic [BYTE_W-1:0]  wdata,
  input  logic               tick,
  output logic               run,
  output logic               load,
  output logic [FRAME_W-1:0] load_val,
  output logic               shift_en,
  output logic               sample_en,
  output logic               cs_n,
  output logic               sclk,
  output logic               busy,
  output logic               done
);

  localparam int unsigned BIT_W = $clog2(FRAME_W);
  localparam logic [BIT_W-1:0] LAST_WR  = BIT_W'(FRAME_W - 1);
  localparam logic [BIT_W-1:0] LAST_RD  = BIT_W'(2 * BYTE_W - 1);
  localparam logic [BIT_W-1:0] FIRST_IN = BIT_W'(BYTE_W);

  phase_e             phase_q, phase_d;
  logic [BIT_W-1:0]   bit_q, bit_d;
  logic [BIT_W-1:0]   last_q, last_d;
  logic               second_q, second_d;
  logic               rw_q, rw_d;
  logic [BYTE_W-1:0]  chip_q, chip_d;
  logic               done_q, done_d;
  logic               adv;

  assign adv = (phase_q == PH_IDLE) ? req : tick;

  always_comb begin
    phase_d   = phase_q;
    bit_d     = bit_q;
    last_d    = last_q;
    second_d  = second_q;
    rw_d      = rw_q;
    chip_d    = chip_q;
    done_d    = 1'b0;
    load      = 1'b0;
    load_val  = '0;
    shift_en  = 1'b0;
    sample_en = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (req) begin
          phase_d  = PH_LOW;
          bit_d    = '0;
          second_d = 1'b0;
          rw_d     = rw;
          chip_d   = chip_addr;
          load     = 1'b1;
          last_d   = rw ? LAST_RD : LAST_WR;
          load_val = rw ? {chip_addr[BYTE_W-1:1], 1'b0, reg_addr, {BYTE_W{1'b0}}}
                        : {chip_addr[BYTE_W-1:1], 1'b0, reg_addr, wdata};
        end
      end
      PH_LOW: begin
        if (tick) begin
          phase_d   = PH_HIGH;
          sample_en = rw_q && second_q && (bit_q >= FIRST_IN);
        end
      end
      PH_HIGH: begin
        if (tick) begin
          if (bit_q == last_q) begin
            phase_d = PH_GAP;
          end else begin
            phase_d  = PH_LOW;
            bit_d    = bit_q + 1'b1;
            shift_en = 1'b1;
          end
        end
      end
      PH_GAP: begin
        if (tick) begin
          if (rw_q && !second_q) begin
            phase_d  = PH_LOW;
            second_d = 1'b1;
            bit_d    = '0;
            last_d   = LAST_RD;
            load     = 1'b1;
            load_val = {chip_q[BYTE_W-1:1], 1'b1, {(2*BYTE_W){1'b0}}};
          end else begin
            phase_d = PH_IDLE;
            done_d  = 1'b1;
          end
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      bit_q    <= '0;
      last_q   <= '0;
      second_q <= 1'b0;
      rw_q     <= 1'b0;
      chip_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= done_d;
      if (adv) begin
        phase_q  <= phase_d;
        bit_q    <= bit_d;
        last_q   <= last_d;
        second_q <= second_d;
        rw_q     <= rw_d;
        chip_q   <= chip_d;
      end
    end
  end

  assign run  = (phase_q != PH_IDLE);
  assign busy = (phase_q != PH_IDLE);
  assign cs_n = (phase_q == PH_IDLE) || (phase_q == PH_GAP);
  assign sclk = (phase_q != PH_LOW);
  assign done = done_q;

  // R6: completion is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: done is seen only once the block is free again
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R7: captured request fields stay put while a transaction runs
  p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE) |=> ($stable(chip_q) && $stable(rw_q)));

endmodule

// File: rtl/spi_reg_master.sv
module spi_reg_master #(
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned HALF_CYC = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              rw,
  input  logic [BYTE_W-1:0] chip_addr,
  input  logic [BYTE_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              busy,
  output logic              done,
  output logic              sclk,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso
);

  localparam int unsigned FRAME_W = 3 * BYTE_W;

  logic [1:0]         rst_pipe;
  logic               rst_s_n;
  logic               run, tick, load, shift_en, sample_en, tx_bit;
  logic [FRAME_W-1:0] load_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  spi_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_s_n),
    .run   (run),
    .tick  (tick)
  );

  spi_txn_seq #(.BYTE_W(BYTE_W), .FRAME_W(FRAME_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .req       (req),
    .rw        (rw),
    .chip_addr (chip_addr),
    .reg_addr  (reg_addr),
    .wdata     (wdata),
    .tick      (tick),
    .run       (run),
    .load      (load),
    .load_val  (load_val),
    .shift_en  (shift_en),
    .sample_en (sample_en),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .busy      (busy),
    .done      (done)
  );

  spi_shift_unit #(.BYTE_W(BYTE_W), .FRAME_W(FRAME_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .load      (load),
    .load_val  (load_val),
    .shift_en  (shift_en),
    .sample_en (sample_en),
    .miso      (miso),
    .tx_bit    (tx_bit),
    .rx_byte   (rdata)
  );

  assign mosi = cs_n ? 1'b0 : tx_bit;

  // R3: data is held across the rising edge and the high half
  p_mosi_hold_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!cs_n && sclk && $past(!cs_n && sclk)) |-> $stable(mosi));

  // R6: no completion pulse without a transaction having run
  p_done_after_busy_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(done) |-> $past(busy));

endmodule

// File: tb/test_spi_reg_master.sv
module test_spi_reg_master;

  localparam int HALF = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0;
  logic       rw = 1'b0;
  logic [7:0] chip_addr = 8'h00;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic       miso = 1'b0;
  logic [7:0] rdata;
  logic       busy, done, sclk, cs_n, mosi;

  int    n_chk = 0;
  int    n_err = 0;
  string tag = "R1";
  bit    junk = 1'b0;
  logic [6:0] exp_q[$];

  always #5 clk = ~clk;

  spi_reg_master #(.BYTE_W(8), .HALF_CYC(HALF)) i_spi_reg_master (
    .clk(clk), .rst_n(rst_n), .req(req), .rw(rw), .chip_addr(chip_addr),
    .reg_addr(reg_addr), .wdata(wdata), .rdata(rdata), .busy(busy),
    .done(done), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  task automatic check(string t, string what, logic [7:0] act, logic [7:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", t, what, act, expv);
    end
  endtask

  // entry: {cs_n, sclk, mosi, busy, done, miso_care, miso_val}
  task automatic cmp_cycle(logic [6:0] e);
    check(tag, "{cs_n,sclk,mosi,busy,done}",
          {3'b000, cs_n, sclk, mosi, busy, done}, {3'b000, e[6:2]});
    junk = ~junk;
    miso = e[1] ? e[0] : junk;
  endtask

  task automatic push_bit(bit ob, bit care, bit val);
    for (int k = 0; k < HALF; k++) exp_q.push_back({1'b0, 1'b0, ob, 1'b1, 1'b0, care, val});
    for (int k = 0; k < HALF; k++) exp_q.push_back({1'b0, 1'b1, ob, 1'b1, 1'b0, 1'b0, 1'b0});
  endtask

  task automatic push_byte(logic [7:0] b);
    for (int k = 7; k >= 0; k--) push_bit(b[k], 1'b0, 1'b0);
  endtask

  task automatic push_gap();
    for (int k = 0; k < HALF; k++) exp_q.push_back(7'b1101000);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cmp_cycle(7'b1100000);
    end
  endtask

  task automatic run_txn(bit r, logic [7:0] ca, logic [7:0] ra, logic [7:0] wd,
                         logic [7:0] resp, int poke);
    exp_q.delete();
    push_byte({ca[7:1], 1'b0});
    push_byte(ra);
    if (!r) begin
      push_byte(wd);
      push_gap();
    end else begin
      push_gap();
      push_byte({ca[7:1], 1'b1});
      for (int k = 7; k >= 0; k--) push_bit(1'b0, 1'b1, resp[k]);
      push_gap();
    end
    exp_q.push_back(7'b1100100);
    rw = r; chip_addr = ca; reg_addr = ra; wdata = wd; req = 1'b1;
    @(negedge clk);
    for (int i = 0; i < exp_q.size(); i++) begin
      cmp_cycle(exp_q[i]);
      if (i == poke) begin
        req = 1'b1; rw = ~r; chip_addr = 8'hC3; reg_addr = 8'h7E; wdata = 8'h18;
      end else begin
        req = 1'b0;
      end
      if (i != exp_q.size() - 1) @(negedge clk);
    end
    if (r) check(tag, "rdata at done (R4 R6)", rdata, resp);
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_err++;
    $display("FAIL R6 watchdog: actual=hung expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    check(tag, "outputs in reset", {3'b000, cs_n, sclk, mosi, busy, done}, 8'b00011000);
    rst_n = 1'b1;
    tag = "R1 R9";
    idle(5);
    // plain write
    tag = "R2 R3 R5 R6";
    run_txn(1'b0, 8'h34, 8'h05, 8'hA5, 8'h00, -1);
    // back-to-back write in the done cycle, chip bit 0 set on input
    tag = "R8 R9 R2";
    run_txn(1'b0, 8'h35, 8'h0C, 8'h3C, 8'h00, -1);
    tag = "R9";
    idle(3);
    // read
    tag = "R4 R5 R6";
    run_txn(1'b1, 8'h20, 8'h04, 8'h00, 8'h5C, -1);
    // read with stray request mid-way and chip bit 0 set
    tag = "R7 R8 R4";
    run_txn(1'b1, 8'h21, 8'h26, 8'h00, 8'hA3, 40);
    // write with stray request during the gap region
    tag = "R7 R2";
    run_txn(1'b0, 8'h9E, 8'hFF, 8'h00, 8'h00, 145);
    // read boundary values
    tag = "R4 boundary";
    run_txn(1'b1, 8'hFF, 8'h00, 8'h00, 8'hFF, -1);
    run_txn(1'b1, 8'h00, 8'h7F, 8'h00, 8'h00, 10);
    tag = "R9 R7";
    idle(6);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule